// File: doc/BRIEF.md
# Serial Interrupt Slot Agent

This block is the peripheral end of a shared serialized interrupt wire. The wire is open-drain with an external pull-up, so the block never drives it directly. It produces a drive-enable and a drive-value, and it reads the resolved wire level back on a separate input. After a host start pulse it counts data frames of three clocks each. In the one frame whose number matches `slot_sel`, it reports the level of `irq_in` using a drive-low, drive-high, release pattern.

The host closes every cycle with a stop pulse, and the block measures how long that pulse is. A 2-clock pulse puts the bus into quiet mode. In quiet mode the block may ask for a cycle itself when its interrupt level no longer matches the level it last reported. It does this by pulling the wire low for one clock, and the host then stretches that low into a full start pulse. A 3-clock pulse puts the bus into continuous mode, where only the host starts cycles. The number of data frames, the accepted start-pulse range and the two stop widths are parameters.

Top module: `sirq_slot_agent`

## Requirements
- R1: While reset is asserted and after it is released, the line is not driven (`line_oe` = 0), the block waits for a start pulse and the bus mode is continuous.
- R2: While waiting, a low on `line_in` for 4 to 8 consecutive clock samples, followed by a high sample, is taken as a start pulse. Frame 0's first clock is the clock period after the edge at which the high was sampled. Low pulses of 3 or 9 samples start nothing.
- R3: In the first clock of its own frame, the block drives the line low (`line_oe` = 1, `line_out` = 0) if `irq_in`, as sampled at the edge that begins that clock, is 0. If it is 1, the block leaves the line undriven.
- R4: In the second clock of its own frame, the block drives the line high (`line_oe` = 1, `line_out` = 1) only if it drove the line low in the clock before. Otherwise it leaves the line undriven.
- R5: In the third clock of its own frame the line is always released.
- R6: Frame k starts 3·k clocks after frame 0. The block drives nothing in any frame whose number is not `slot_sel`.
- R7: After the last data frame (frame N_FRAMES-1), the next low pulse is a stop pulse. A 2-clock stop selects quiet mode, a 3-clock stop selects continuous mode, and any other width leaves the mode unchanged.
- R8: In quiet mode, while waiting with the line high, the block requests a cycle when `irq_in` differs from the level it last reported (that level is 1 after reset). It requests by driving the line low for exactly one clock, in the clock after the edge that sees the difference. It makes at most one request per start pulse.
- R9: In continuous mode the block never drives the line outside its own frame, whatever `irq_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Resolved level of the shared wire |
| line_oe | output | 1 | Drive enable for the wire; 0 leaves it to the pull-up |
| line_out | output | 1 | Level driven onto the wire when `line_oe` is 1 |
| slot_sel | input | SLOT_W | Number of the data frame this agent owns |
| irq_in | input | 1 | Interrupt level to report; 0 is reported as a low on the wire |

## Verification
The slot drive is tried with the interrupt low and high, in the first, a middle and the last frame, and after start pulses of the shortest, longest and intermediate accepted widths. These cases separate a frame-position error from an off-by-one in start recognition or in the last-frame count. Start pulses of 3 and 9 clocks are sent with the interrupt low, so a pulse wrongly accepted shows up as an unexpected drive. Stop widths of 2, 3 and 4 are each followed by an interrupt change: whether a one-clock request appears shows which mode the agent is in, including the case where the mode must stay unchanged.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FRAMES = 2'd1,
    SQ_STOP   = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } ph_e;

endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic s0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      s0_q  <= 1'b1;
      rst_q <= s0_q;
    end
  end

endmodule

// File: rtl/sirq_seq.sv
// Frame sequencer: start-pulse detection, frame/phase counting and stop-width mode decode.
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int N_FRAMES   = 21,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int SLOT_W     = $clog2(N_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output seq_st_e           st_q,
  output seq_st_e           st_n,
  output ph_e               ph_n,
  output logic [SLOT_W-1:0] frm_q,
  output logic [SLOT_W-1:0] frm_n,
  output logic              quiet_q,
  output logic              start_hit
);

  localparam int LOW_W = $clog2(START_MAX + 2);
  localparam logic [LOW_W-1:0] LOW_SAT   = '1;
  localparam logic [LOW_W-1:0] LOW_MIN   = LOW_W'(START_MIN);
  localparam logic [LOW_W-1:0] LOW_MAX   = LOW_W'(START_MAX);
  localparam logic [LOW_W-1:0] LOW_QUIET = LOW_W'(STOP_QUIET);
  localparam logic [LOW_W-1:0] LOW_CONT  = LOW_W'(STOP_CONT);
  localparam logic [SLOT_W-1:0] FRM_LAST = SLOT_W'(N_FRAMES - 1);

  ph_e              ph_q;
  logic [LOW_W-1:0] low_q, low_n;
  logic             quiet_n, mode_en;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    frm_n   = frm_q;
    low_n   = low_q;
    quiet_n = quiet_q;
    mode_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (!line_in) begin
          low_n = (low_q == LOW_SAT) ? low_q : low_q + 1'b1;
        end else begin
          low_n = '0;
          if (low_q >= LOW_MIN && low_q <= LOW_MAX) begin
            st_n  = SQ_FRAMES;
            ph_n  = PH_SAMPLE;
            frm_n = '0;
          end
        end
      end
      SQ_FRAMES: begin
        if (ph_q == PH_TURN) begin
          ph_n = PH_SAMPLE;
          if (frm_q == FRM_LAST) begin
            st_n  = SQ_STOP;
            low_n = '0;
          end else begin
            frm_n = frm_q + 1'b1;
          end
        end else begin
          ph_n = ph_e'(ph_q + 2'd1);
        end
      end
      SQ_STOP: begin
        if (!line_in) begin
          low_n = (low_q == LOW_SAT) ? low_q : low_q + 1'b1;
        end else if (low_q != '0) begin
          st_n  = SQ_IDLE;
          low_n = '0;
          if (low_q == LOW_QUIET) begin
            quiet_n = 1'b1;
            mode_en = 1'b1;
          end else if (low_q == LOW_CONT) begin
            quiet_n = 1'b0;
            mode_en = 1'b1;
          end
        end
      end
      default: begin
        st_n  = SQ_IDLE;
        low_n = '0;
      end
    endcase
  end

  assign start_hit = (st_q == SQ_IDLE) && (st_n == SQ_FRAMES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ph_q  <= PH_SAMPLE;
      frm_q <= '0;
      low_q <= '0;
    end else begin
      st_q  <= st_n;
      ph_q  <= ph_n;
      frm_q <= frm_n;
      low_q <= low_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= 1'b0;
    end else if (mode_en) begin
      quiet_q <= quiet_n;
    end
  end

endmodule

// File: rtl/sirq_drv.sv
// Line driver: three-phase slot drive and quiet-mode start request.
module sirq_drv
  import sirq_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              irq_in,
  input  logic [SLOT_W-1:0] slot_sel,
  input  seq_st_e           st_q,
  input  seq_st_e           st_n,
  input  ph_e               ph_n,
  input  logic [SLOT_W-1:0] frm_n,
  input  logic              quiet_q,
  input  logic              start_hit,
  output logic              line_oe,
  output logic              line_out
);

  logic oe_n, out_n;
  logic rpt_q, rpt_n, rpt_en;
  logic req_q, req_n, req_en;
  logic own_n, req_cond;

  assign own_n    = (st_n == SQ_FRAMES) && (frm_n == slot_sel);
  assign req_cond = (st_q == SQ_IDLE) && (st_n == SQ_IDLE) && quiet_q &&
                    line_in && (irq_in != rpt_q) && !req_q;

  always_comb begin
    oe_n  = 1'b0;
    out_n = 1'b0;
    if (own_n) begin
      unique case (ph_n)
        PH_SAMPLE: begin
          oe_n  = !irq_in;
          out_n = 1'b0;
        end
        PH_RECOV: begin
          oe_n  = line_oe && !line_out;
          out_n = 1'b1;
        end
        default: begin
          oe_n  = 1'b0;
          out_n = 1'b0;
        end
      endcase
    end else if (req_cond) begin
      oe_n  = 1'b1;
      out_n = 1'b0;
    end
  end

  always_comb begin
    rpt_en = own_n && (ph_n == PH_SAMPLE);
    rpt_n  = irq_in;
    req_en = req_cond || start_hit;
    req_n  = req_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_oe  <= 1'b0;
      line_out <= 1'b0;
    end else begin
      line_oe  <= oe_n;
      line_out <= out_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q <= 1'b1;
    end else if (rpt_en) begin
      rpt_q <= rpt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_n;
    end
  end

endmodule

// File: rtl/sirq_slot_agent.sv
module sirq_slot_agent
  import sirq_pkg::*;
#(
  parameter int N_FRAMES   = 21,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int SLOT_W     = $clog2(N_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              line_oe,
  output logic              line_out,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              irq_in
);

  logic              rst_q;
  seq_st_e           st_q, st_n;
  ph_e               ph_n;
  logic [SLOT_W-1:0] frm_q, frm_n;
  logic              quiet_q, start_hit;

  sirq_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  sirq_seq #(
    .N_FRAMES   (N_FRAMES),
    .START_MIN  (START_MIN),
    .START_MAX  (START_MAX),
    .STOP_QUIET (STOP_QUIET),
    .STOP_CONT  (STOP_CONT),
    .SLOT_W     (SLOT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .line_in   (line_in),
    .st_q      (st_q),
    .st_n      (st_n),
    .ph_n      (ph_n),
    .frm_q     (frm_q),
    .frm_n     (frm_n),
    .quiet_q   (quiet_q),
    .start_hit (start_hit)
  );

  sirq_drv #(
    .SLOT_W (SLOT_W)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_q),
    .line_in   (line_in),
    .irq_in    (irq_in),
    .slot_sel  (slot_sel),
    .st_q      (st_q),
    .st_n      (st_n),
    .ph_n      (ph_n),
    .frm_n     (frm_n),
    .quiet_q   (quiet_q),
    .start_hit (start_hit),
    .line_oe   (line_oe),
    .line_out  (line_out)
  );

endmodule

// File: rtl/sirq_slot_agent_chk.sv
module sirq_slot_agent_chk
  import sirq_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_q,
  input logic              line_oe,
  input logic              line_out,
  input seq_st_e           st_q,
  input logic [SLOT_W-1:0] frm_q,
  input logic [SLOT_W-1:0] slot_sel,
  input logic              quiet_q
);

  a_r4_high_after_low: assert property (@(posedge clk) disable iff (!rst_q)
    (line_oe && line_out) |-> $past(line_oe && !line_out));

  a_r5_turn_release: assert property (@(posedge clk) disable iff (!rst_q)
    (line_oe && line_out) |=> !line_oe);

  a_r6_own_frame_only: assert property (@(posedge clk) disable iff (!rst_q)
    (line_oe && st_q == SQ_FRAMES) |-> (frm_q == slot_sel));

  a_r8_one_clock_req: assert property (@(posedge clk) disable iff (!rst_q)
    (line_oe && !line_out && st_q == SQ_IDLE) |=> !line_oe);

  a_r9_no_req_cont: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_IDLE && $past(st_q == SQ_IDLE) && $past(!quiet_q)) |-> !line_oe);

endmodule

bind sirq_slot_agent sirq_slot_agent_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .line_oe  (line_oe),
  .line_out (line_out),
  .st_q     (st_q),
  .frm_q    (frm_q),
  .slot_sel (slot_sel),
  .quiet_q  (quiet_q)
);

// File: tb/sirq_slot_agent_tb.sv
`timescale 1ns/1ps
module sirq_slot_agent_tb;

  localparam int N  = 21;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n, host_low, irq, oe, out;
  logic [SW-1:0] slot;
  logic          line_in;
  int            cyc, checks, errors;
  bit            done;

  int    q_cyc[$];
  bit    q_oe[$];
  bit    q_out[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  // wired line with pull-up: any low driver wins
  assign line_in = ~(host_low | (oe & ~out));

  sirq_slot_agent #(.N_FRAMES(N)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .line_oe  (oe),
    .line_out (out),
    .slot_sel (slot),
    .irq_in   (irq)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic expect_at(int c, bit o, bit v, string r);
    q_cyc.push_back(c);
    q_oe.push_back(o);
    q_out.push_back(v);
    q_req.push_back(r);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (oe && out && host_low) begin
        errors++;
        $display("FAIL R4 contention at cycle %0d: oe=%0d out=%0d expected no high drive while host low", cyc, oe, out);
      end
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        checks++;
        if (oe !== q_oe[0] || (q_oe[0] && out !== q_out[0])) begin
          errors++;
          $display("FAIL %s cycle %0d: oe=%0d out=%0d expected oe=%0d out=%0d",
                   q_req[0], cyc, oe, out, q_oe[0], q_out[0]);
        end
        void'(q_cyc.pop_front()); void'(q_oe.pop_front());
        void'(q_out.pop_front()); void'(q_req.pop_front());
      end else if (oe) begin
        errors++;
        $display("FAIL R6/R9 unexpected drive at cycle %0d: oe=%0d out=%0d expected oe=0", cyc, oe, out);
      end
    end
  end

  // host start pulse of len samples; queues the own-slot expectations (R2, R3, R4, R5, R6)
  task automatic host_start(int len);
    int c, t;
    c = cyc;
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    t = c + len + 1 + 3 * int'(slot);
    if (!irq) begin
      expect_at(t,     1, 0, "R3");
      expect_at(t + 1, 1, 1, "R4");
    end else begin
      expect_at(t,     0, 0, "R3");
      expect_at(t + 1, 0, 0, "R4");
    end
    expect_at(t + 2, 0, 0, "R5");
    repeat (3 * N + 1) @(negedge clk);
  endtask

  task automatic host_stop(int w);
    host_low = 1'b1;
    repeat (w) @(negedge clk);
    host_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // pulse that must not count as a start (R2)
  task automatic host_pulse(int len);
    int c, t;
    c = cyc;
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    t = c + len + 1 + 3 * int'(slot);
    expect_at(t,     0, 0, "R2");
    expect_at(t + 1, 0, 0, "R2");
    repeat (3 * N + 5) @(negedge clk);
  endtask

  task automatic idle_watch(int n, string r);
    for (int i = 1; i <= n; i++) expect_at(cyc + i, 0, 0, r);
    repeat (n + 1) @(negedge clk);
  endtask

  // called right after irq changes at a negedge in quiet mode (R8)
  task automatic request_and_start(int len);
    expect_at(cyc + 1, 1, 0, "R8");
    expect_at(cyc + 2, 0, 0, "R8");
    @(negedge clk);
    host_start(len);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; host_low = 1'b0; irq = 1'b1; slot = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: oe=%0d expected 0", oe);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: oe=%0d expected 0", oe);
    end

    // continuous after reset: no request even though irq differs (R1, R9)
    slot = SW'(5);
    irq  = 1'b0;
    idle_watch(8, "R9");
    host_start(4);           // shortest start, drive low in slot 5
    host_stop(3);            // continuous (R7)

    irq = 1'b1;
    idle_watch(6, "R9");
    slot = '0;
    host_start(8);           // longest start, slot 0, irq high -> released
    host_stop(2);            // quiet (R7)

    idle_watch(4, "R8");     // irq equals reported level: no request
    slot = SW'(N - 1);
    irq  = 1'b0;
    request_and_start(5);    // request then last frame drives low
    host_stop(4);            // width 4: mode unchanged (R7)

    slot = SW'(2);
    host_pulse(3);           // too short (R2)
    host_pulse(9);           // too long (R2)

    irq = 1'b1;
    request_and_start(6);    // still quiet after width-4 stop (R7)
    host_stop(3);            // continuous

    irq = 1'b0;
    idle_watch(8, "R9");
    slot = SW'(3);
    host_start(7);
    host_stop(2);
    repeat (4) @(negedge clk);

    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL R6 %0d expected items never reached: actual %0d expected 0", q_cyc.size(), q_cyc.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule